// File: doc/BRIEF.md
# MESI Line State Controller

This block tracks the coherence state of every line in a small direct-mapped private cache that sits on a shared snooping bus. Each line is Invalid, Shared, Exclusive or Modified. A line is one data word, so the tag, state and data of a line are stored together. On the processor side the block takes one read or write request at a time. On the bus side it starts its own transactions and answers the transactions that other caches start.

A bus transaction takes one clock cycle, and snoop answers are combinational within that cycle. The requester drives a command and an address. Every other cache decodes them. A snooper that holds the block in any valid state raises its shared output. A snooper that holds the block Modified also raises its flush output and drives the line's data. Outside the block, the shared outputs of the other caches are ORed into the requester's shared input. The fill data is the flushed word when there is a flush, and the memory word otherwise. Bus arbitration and the memory are outside the block: only one cache drives a command in any cycle.

The main gain over a three-state protocol comes from the Exclusive state. A read miss that no other cache shares fills the line as Exclusive. A later write to that line then moves it to Modified with no bus transaction at all.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready_o` is high, `cpu_done_o` is low and `bus_cmd_o` is 0 (idle).
- R2: A read miss drives `bus_cmd_o` = 1 (read) with the request address for one cycle, and `cpu_done_o` follows in the next cycle with the fill data. A read hit raises `cpu_done_o` one cycle after acceptance with the stored word and starts no bus transaction.
- R3: A line filled by a read miss becomes Exclusive if `bus_shared_i` was low during the read, and Shared if it was high.
- R4: A write that hits an Exclusive or Modified line updates the word, leaves the line Modified and starts no bus transaction.
- R5: A write that hits a Shared line issues `bus_cmd_o` = 3 (upgrade) and leaves the line Modified. Every other copy becomes Invalid.
- R6: A write miss issues `bus_cmd_o` = 2 (read-for-ownership), and the line ends Modified and holds the written word.
- R7: A snooped read (`snp_cmd_i` = 1) that hits a valid line raises `snp_shared_o` and leaves the line Shared. If the line was Modified, the block also raises `snp_flush_o` and drives the line's word on `snp_data_o`.
- R8: A snooped read-for-ownership (code 2) or upgrade (code 3) that hits a valid line makes it Invalid. A Modified line flushes its word in the same cycle.
- R9: A miss whose set holds a Modified line first issues `bus_cmd_o` = 4 (write-back) with the old address and word, then the fetch. A miss that replaces an Exclusive or Shared line is silent.
- R10: Across several caches on one bus, every read returns the most recent value written to that address by any cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_valid_i | input | 1 | Processor request present |
| cpu_we_i | input | 1 | Request is a write |
| cpu_addr_i | input | AW | Word address of the request |
| cpu_wdata_i | input | DW | Write data |
| cpu_ready_o | output | 1 | Request is taken at this edge if valid |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DW | Read result, valid with done |
| bus_cmd_o | output | 3 | Own command: 0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back |
| bus_addr_o | output | AW | Address of own command |
| bus_data_o | output | DW | Write-back data |
| bus_shared_i | input | 1 | Another cache holds the block being read |
| bus_fill_i | input | DW | Fill word for own read or read-for-ownership |
| snp_cmd_i | input | 3 | Command issued by another cache |
| snp_addr_i | input | AW | Address of snooped command |
| snp_shared_o | output | 1 | This cache holds the snooped block on a read |
| snp_flush_o | output | 1 | This cache supplies the snooped block's data |
| snp_data_o | output | DW | Flushed word |

## Verification
The bench runs three caches on one modelled bus. It walks a single address through every state transition. It checks each operation's exact bus command sequence and shared flag, and checks that every read returns the latest write. A design that skipped the silent upgrade would show an extra upgrade command. One that kept Exclusive after a snooped read would upgrade silently and lose coherence. One that lost a flush or a write-back would return a stale word on a later read. Replacement is tested both ways. A Modified victim must produce a write-back whose data a later reader sees. A Shared victim must leave the bus quiet apart from the fetch.

// File: rtl/mesi_lsc_pkg.sv
package mesi_lsc_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_RD   = 3'd1,
    CMD_RDX  = 3'd2,
    CMD_UPGR = 3'd3,
    CMD_WB   = 3'd4
  } bus_cmd_e;
endpackage

// File: rtl/mesi_lsc_array.sv
module mesi_lsc_array
  import mesi_lsc_pkg::*;
#(
  parameter int SETS = 4,
  parameter int TAGW = 14,
  parameter int DW   = 32,
  localparam int IDXW = $clog2(SETS)
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [IDXW-1:0] a_idx_i,
  output line_st_e        a_st_o,
  output logic [TAGW-1:0] a_tag_o,
  output logic [DW-1:0]   a_data_o,
  input  logic [IDXW-1:0] b_idx_i,
  output line_st_e        b_st_o,
  output logic [TAGW-1:0] b_tag_o,
  output logic [DW-1:0]   b_data_o,
  input  logic            fill_en_i,
  input  logic [IDXW-1:0] fill_idx_i,
  input  logic [TAGW-1:0] fill_tag_i,
  input  line_st_e        fill_st_i,
  input  logic [DW-1:0]   fill_data_i,
  input  logic            snp_en_i,
  input  logic [IDXW-1:0] snp_idx_i,
  input  line_st_e        snp_st_i
);
  line_st_e        st_arr   [SETS];
  logic [TAGW-1:0] tag_arr  [SETS];
  logic [DW-1:0]   data_arr [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    line_st_e        st_q;
    logic [TAGW-1:0] tag_q;
    logic [DW-1:0]   data_q;
    logic            snp_hit, fill_hit;

    assign snp_hit  = snp_en_i  && (snp_idx_i  == IDXW'(g));
    assign fill_hit = fill_en_i && (fill_idx_i == IDXW'(g));

    // the snoop update wins: the bus owner's order is the global order
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)       st_q <= ST_I;
      else if (snp_hit)  st_q <= snp_st_i;
      else if (fill_hit) st_q <= fill_st_i;
    end

    always_ff @(posedge clk) begin
      if (fill_hit) begin
        tag_q  <= fill_tag_i;
        data_q <= fill_data_i;
      end
    end

    assign st_arr[g]   = st_q;
    assign tag_arr[g]  = tag_q;
    assign data_arr[g] = data_q;
  end

  assign a_st_o   = st_arr[a_idx_i];
  assign a_tag_o  = tag_arr[a_idx_i];
  assign a_data_o = data_arr[a_idx_i];
  assign b_st_o   = st_arr[b_idx_i];
  assign b_tag_o  = tag_arr[b_idx_i];
  assign b_data_o = data_arr[b_idx_i];
endmodule

// File: rtl/mesi_lsc_snoop.sv
module mesi_lsc_snoop
  import mesi_lsc_pkg::*;
#(
  parameter int TAGW = 14,
  parameter int DW   = 32
) (
  input  bus_cmd_e        cmd_i,
  input  logic [TAGW-1:0] tag_i,
  input  line_st_e        st_i,
  input  logic [TAGW-1:0] line_tag_i,
  input  logic [DW-1:0]   line_data_i,
  output logic            shared_o,
  output logic            flush_o,
  output logic [DW-1:0]   data_o,
  output logic            upd_en_o,
  output line_st_e        upd_st_o
);
  logic hit;
  assign hit = (st_i != ST_I) && (line_tag_i == tag_i);

  always_comb begin
    shared_o = 1'b0;
    flush_o  = 1'b0;
    upd_en_o = 1'b0;
    upd_st_o = ST_I;
    if (hit) begin
      unique case (cmd_i)
        CMD_RD: begin
          shared_o = 1'b1;
          flush_o  = (st_i == ST_M);
          upd_en_o = (st_i != ST_S);
          upd_st_o = ST_S;
        end
        CMD_RDX: begin
          flush_o  = (st_i == ST_M);
          upd_en_o = 1'b1;
        end
        CMD_UPGR: upd_en_o = 1'b1;
        default: ;
      endcase
    end
  end

  assign data_o = flush_o ? line_data_i : '0;
endmodule

// File: rtl/mesi_lsc_ctrl.sv
module mesi_lsc_ctrl
  import mesi_lsc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int IDXW = 2,
  localparam int TAGW = AW - IDXW
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            cpu_valid_i,
  input  logic            cpu_we_i,
  input  logic [AW-1:0]   cpu_addr_i,
  input  logic [DW-1:0]   cpu_wdata_i,
  input  logic            stall_i,
  output logic            cpu_ready_o,
  output logic            cpu_done_o,
  output logic [DW-1:0]   cpu_rdata_o,
  output logic [IDXW-1:0] look_idx_o,
  input  line_st_e        line_st_i,
  input  logic [TAGW-1:0] line_tag_i,
  input  logic [DW-1:0]   line_data_i,
  output logic            fill_en_o,
  output logic [IDXW-1:0] fill_idx_o,
  output logic [TAGW-1:0] fill_tag_o,
  output line_st_e        fill_st_o,
  output logic [DW-1:0]   fill_data_o,
  output bus_cmd_e        bus_cmd_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_data_o,
  input  logic            bus_shared_i,
  input  logic [DW-1:0]   bus_fill_i
);
  typedef enum logic [1:0] {F_IDLE, F_EVICT, F_XFER} fsm_e;

  fsm_e          state_q, state_d;
  logic          done_q, done_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          load;
  bus_cmd_e      cmd_q, cmd_d;
  logic          req_we_q;
  logic [AW-1:0] req_addr_q;
  logic [DW-1:0] req_wdata_q;

  logic [IDXW-1:0] cpu_idx, req_idx;
  logic [TAGW-1:0] cpu_tag, req_tag;
  logic            hit;

  assign cpu_idx = cpu_addr_i[IDXW-1:0];
  assign cpu_tag = cpu_addr_i[AW-1:IDXW];
  assign req_idx = req_addr_q[IDXW-1:0];
  assign req_tag = req_addr_q[AW-1:IDXW];
  assign look_idx_o  = (state_q == F_IDLE) ? cpu_idx : req_idx;
  assign hit         = (line_st_i != ST_I) && (line_tag_i == cpu_tag);
  assign cpu_ready_o = (state_q == F_IDLE) && !stall_i;

  always_comb begin
    state_d     = state_q;
    done_d      = 1'b0;
    rdata_d     = rdata_q;
    load        = 1'b0;
    cmd_d       = cmd_q;
    fill_en_o   = 1'b0;
    fill_idx_o  = req_idx;
    fill_tag_o  = req_tag;
    fill_st_o   = ST_M;
    fill_data_o = req_wdata_q;
    bus_cmd_o   = CMD_NONE;
    bus_addr_o  = req_addr_q;
    bus_data_o  = '0;
    unique case (state_q)
      F_IDLE: begin
        if (cpu_valid_i && cpu_ready_o) begin
          if (hit && !cpu_we_i) begin
            done_d  = 1'b1;
            rdata_d = line_data_i;
          end else if (hit && line_st_i != ST_S) begin
            fill_en_o   = 1'b1;
            fill_idx_o  = cpu_idx;
            fill_tag_o  = cpu_tag;
            fill_data_o = cpu_wdata_i;
            done_d      = 1'b1;
            rdata_d     = cpu_wdata_i;
          end else begin
            load = 1'b1;
            if (hit)           cmd_d = CMD_UPGR;
            else if (cpu_we_i) cmd_d = CMD_RDX;
            else               cmd_d = CMD_RD;
            state_d = (!hit && line_st_i == ST_M) ? F_EVICT : F_XFER;
          end
        end
      end
      F_EVICT: begin
        bus_cmd_o   = CMD_WB;
        bus_addr_o  = {line_tag_i, req_idx};
        bus_data_o  = line_data_i;
        fill_en_o   = 1'b1;
        fill_tag_o  = line_tag_i;
        fill_st_o   = ST_I;
        fill_data_o = line_data_i;
        state_d     = F_XFER;
      end
      F_XFER: begin
        bus_cmd_o   = cmd_q;
        fill_en_o   = 1'b1;
        fill_st_o   = (cmd_q == CMD_RD) ? (bus_shared_i ? ST_S : ST_E) : ST_M;
        fill_data_o = req_we_q ? req_wdata_q : bus_fill_i;
        done_d      = 1'b1;
        rdata_d     = fill_data_o;
        state_d     = F_IDLE;
      end
      default: state_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= F_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (done_d) rdata_q <= rdata_d;
    if (load) begin
      cmd_q       <= cmd_d;
      req_we_q    <= cpu_we_i;
      req_addr_q  <= cpu_addr_i;
      req_wdata_q <= cpu_wdata_i;
    end
  end

  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_lsc_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int SETS = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cpu_valid_i,
  input  logic          cpu_we_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_ready_o,
  output logic          cpu_done_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic [2:0]    bus_cmd_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_data_o,
  input  logic          bus_shared_i,
  input  logic [DW-1:0] bus_fill_i,
  input  logic [2:0]    snp_cmd_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_shared_o,
  output logic          snp_flush_o,
  output logic [DW-1:0] snp_data_o
);
  localparam int IDXW = $clog2(SETS);
  localparam int TAGW = AW - IDXW;

  bus_cmd_e        snp_cmd, own_cmd;
  logic [IDXW-1:0] snp_idx, look_idx, fill_idx;
  logic [TAGW-1:0] snp_tag;
  logic            stall;
  line_st_e        a_st, b_st, fill_st, upd_st;
  logic [TAGW-1:0] a_tag, b_tag, fill_tag;
  logic [DW-1:0]   a_data, b_data, fill_data;
  logic            fill_en, upd_en;

  assign snp_cmd = bus_cmd_e'(snp_cmd_i);
  assign snp_idx = snp_addr_i[IDXW-1:0];
  assign snp_tag = snp_addr_i[AW-1:IDXW];
  // hold a new request off while a snoop touches the same set
  assign stall   = (snp_cmd != CMD_NONE) && (snp_idx == cpu_addr_i[IDXW-1:0]);

  mesi_lsc_array #(.SETS(SETS), .TAGW(TAGW), .DW(DW)) u_array (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .a_idx_i     (look_idx),
    .a_st_o      (a_st),
    .a_tag_o     (a_tag),
    .a_data_o    (a_data),
    .b_idx_i     (snp_idx),
    .b_st_o      (b_st),
    .b_tag_o     (b_tag),
    .b_data_o    (b_data),
    .fill_en_i   (fill_en),
    .fill_idx_i  (fill_idx),
    .fill_tag_i  (fill_tag),
    .fill_st_i   (fill_st),
    .fill_data_i (fill_data),
    .snp_en_i    (upd_en),
    .snp_idx_i   (snp_idx),
    .snp_st_i    (upd_st)
  );

  mesi_lsc_snoop #(.TAGW(TAGW), .DW(DW)) u_snoop (
    .cmd_i       (snp_cmd),
    .tag_i       (snp_tag),
    .st_i        (b_st),
    .line_tag_i  (b_tag),
    .line_data_i (b_data),
    .shared_o    (snp_shared_o),
    .flush_o     (snp_flush_o),
    .data_o      (snp_data_o),
    .upd_en_o    (upd_en),
    .upd_st_o    (upd_st)
  );

  mesi_lsc_ctrl #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_ctrl (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .cpu_valid_i  (cpu_valid_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .stall_i      (stall),
    .cpu_ready_o  (cpu_ready_o),
    .cpu_done_o   (cpu_done_o),
    .cpu_rdata_o  (cpu_rdata_o),
    .look_idx_o   (look_idx),
    .line_st_i    (a_st),
    .line_tag_i   (a_tag),
    .line_data_i  (a_data),
    .fill_en_o    (fill_en),
    .fill_idx_o   (fill_idx),
    .fill_tag_o   (fill_tag),
    .fill_st_o    (fill_st),
    .fill_data_o  (fill_data),
    .bus_cmd_o    (own_cmd),
    .bus_addr_o   (bus_addr_o),
    .bus_data_o   (bus_data_o),
    .bus_shared_i (bus_shared_i),
    .bus_fill_i   (bus_fill_i)
  );

  assign bus_cmd_o = own_cmd;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
  input logic       clk,
  input logic       rst_ni,
  input logic       cpu_ready_o,
  input logic       cpu_done_o,
  input logic [2:0] bus_cmd_o,
  input logic [2:0] snp_cmd_i,
  input logic       snp_shared_o,
  input logic       snp_flush_o
);
  // R7, R8: data is flushed only for a snooped read or read-for-ownership
  p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    snp_flush_o |-> (snp_cmd_i == 3'd1 || snp_cmd_i == 3'd2));

  // R7: the shared answer belongs to snooped reads only
  p_shared_on_read_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    snp_shared_o |-> (snp_cmd_i == 3'd1));

  // R2: a fetch or upgrade completes in the following cycle
  p_fetch_done_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2 || bus_cmd_o == 3'd3) |=> cpu_done_o);

  // R9: a write-back is followed directly by the fetch of the new block
  p_wb_then_fetch_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_cmd_o == 3'd4) |=> (bus_cmd_o == 3'd1 || bus_cmd_o == 3'd2));

  // R1: no new request is taken while a transaction of its own is on the bus
  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_cmd_o != 3'd0) |-> !cpu_ready_o);
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .cpu_ready_o  (cpu_ready_o),
  .cpu_done_o   (cpu_done_o),
  .bus_cmd_o    (bus_cmd_o),
  .snp_cmd_i    (snp_cmd_i),
  .snp_shared_o (snp_shared_o),
  .snp_flush_o  (snp_flush_o)
);

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NC = 3;

  logic clk, rst_n;
  int   errors = 0;
  int   checks = 0;

  logic          cv [NC];
  logic          cwe [NC];
  logic [AW-1:0] caddr [NC];
  logic [DW-1:0] cwd [NC];
  logic          crdy [NC];
  logic          cdone [NC];
  logic [DW-1:0] crd [NC];
  logic [2:0]    bcmd [NC];
  logic [AW-1:0] baddr [NC];
  logic [DW-1:0] bdat [NC];
  logic          bsh [NC];
  logic [2:0]    scmd [NC];
  logic          ssh [NC];
  logic          sfl [NC];
  logic [DW-1:0] sdat [NC];
  logic [2:0]    m_cmd;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wb;
  logic          any_fl;
  logic [DW-1:0] fl_data, bfill;

  logic [DW-1:0] mem [int];
  logic [DW-1:0] gold [int];

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return 32'h5A00_0000 | DW'(a);
  endfunction

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return init_val(a);
  endfunction

  initial clk = 1'b0;
  always #4 clk = ~clk;

  for (genvar g = 0; g < NC; g++) begin : g_c
    mesi_line_ctrl #(.AW(AW), .DW(DW), .SETS(4)) dut_i (
      .clk          (clk),
      .rst_ni       (rst_n),
      .cpu_valid_i  (cv[g]),
      .cpu_we_i     (cwe[g]),
      .cpu_addr_i   (caddr[g]),
      .cpu_wdata_i  (cwd[g]),
      .cpu_ready_o  (crdy[g]),
      .cpu_done_o   (cdone[g]),
      .cpu_rdata_o  (crd[g]),
      .bus_cmd_o    (bcmd[g]),
      .bus_addr_o   (baddr[g]),
      .bus_data_o   (bdat[g]),
      .bus_shared_i (bsh[g]),
      .bus_fill_i   (bfill),
      .snp_cmd_i    (scmd[g]),
      .snp_addr_i   (m_addr),
      .snp_shared_o (ssh[g]),
      .snp_flush_o  (sfl[g]),
      .snp_data_o   (sdat[g])
    );
  end

  // bus master select and snoop broadcast
  always_comb begin
    m_cmd  = 3'd0;
    m_addr = '0;
    m_wb   = '0;
    for (int j = 0; j < NC; j++) begin
      if (bcmd[j] != 3'd0) begin
        m_cmd  = bcmd[j];
        m_addr = baddr[j];
        m_wb   = bdat[j];
      end
    end
    for (int i = 0; i < NC; i++) scmd[i] = (bcmd[i] != 3'd0) ? 3'd0 : m_cmd;
  end

  // wired shared line and fill data
  always_comb begin
    any_fl  = 1'b0;
    fl_data = '0;
    for (int j = 0; j < NC; j++) begin
      if (sfl[j]) begin
        any_fl  = 1'b1;
        fl_data = sdat[j];
      end
    end
    for (int i = 0; i < NC; i++) begin
      bsh[i] = 1'b0;
      for (int j = 0; j < NC; j++) if (j != i && ssh[j]) bsh[i] = 1'b1;
    end
    bfill = any_fl ? fl_data : mem_rd(m_addr);
  end

  always @(posedge clk) begin
    if (any_fl) mem[int'(m_addr)] = fl_data;
    if (m_cmd == 3'd4) mem[int'(m_addr)] = m_wb;
  end

  // scoreboard
  typedef struct {
    int            c;
    bit            rd;
    logic [DW-1:0] d;
    string         tag;
  } sb_item_t;
  sb_item_t sbq [$];

  always @(negedge clk) begin
    for (int i = 0; i < NC; i++) begin
      if (rst_n && cdone[i]) begin
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R2: unexpected done on cache %0d (actual 1, expected 0)", i);
        end else begin
          sb_item_t it;
          it = sbq.pop_front();
          if (it.c != i || (it.rd && crd[i] !== it.d)) begin
            errors++;
            $display("FAIL %s: cache %0d rdata actual %h expected %h (cache exp %0d)",
                     it.tag, i, crd[i], it.d, it.c);
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one processor operation; c1/c2 are the expected bus commands, exp_sh<0 skips
  task automatic op(input int c, input bit we, input logic [AW-1:0] a,
                    input logic [DW-1:0] wd, input logic [2:0] c1, input logic [2:0] c2,
                    input int exp_sh, input string tag);
    sb_item_t it;
    logic [2:0] got [2];
    int n;
    n = 0;
    got[0] = 3'd0;
    got[1] = 3'd0;
    it.c   = c;
    it.rd  = !we;
    it.d   = gold.exists(int'(a)) ? gold[int'(a)] : init_val(a);
    it.tag = tag;
    if (we) gold[int'(a)] = wd;
    sbq.push_back(it);
    @(negedge clk);
    cv[c] = 1'b1; cwe[c] = we; caddr[c] = a; cwd[c] = wd;
    @(negedge clk);
    cv[c] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      if (bcmd[c] != 3'd0) begin
        if (n < 2) got[n] = bcmd[c];
        if (bcmd[c] == 3'd1 && exp_sh >= 0)
          check(int'(bsh[c]) == exp_sh, tag, "shared line", int'(bsh[c]), exp_sh);
        n++;
      end
      if (cdone[c]) break;
      @(negedge clk);
    end
    check(got[0] == c1, tag, "first bus cmd", int'(got[0]), int'(c1));
    check(got[1] == c2, tag, "second bus cmd", int'(got[1]), int'(c2));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) begin
      cv[i] = 1'b0; cwe[i] = 1'b0; caddr[i] = '0; cwd[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      check(crdy[i] == 1'b1, "R1", "ready after reset", int'(crdy[i]), 1);
      check(cdone[i] == 1'b0, "R1", "done after reset", int'(cdone[i]), 0);
      check(bcmd[i] == 3'd0, "R1", "bus cmd after reset", int'(bcmd[i]), 0);
    end
    // caches: 0 = A, 1 = B, 2 = C; commands 1 rd, 2 rdx, 3 upgr, 4 wb
    op(0, 0, 16'h0010, '0,           3'd1, 3'd0,  0, "R2");  // cold miss -> E
    op(0, 1, 16'h0010, 32'h1111_1111, 3'd0, 3'd0, -1, "R4");  // silent E->M
    op(1, 0, 16'h0010, '0,           3'd1, 3'd0,  1, "R7");  // A flushes, both S
    op(2, 0, 16'h0010, '0,           3'd1, 3'd0,  1, "R3");  // shared fill
    op(1, 1, 16'h0010, 32'h2222_2222, 3'd3, 3'd0, -1, "R5");  // S upgrade
    op(0, 0, 16'h0010, '0,           3'd1, 3'd0,  1, "R7");  // B flushes M
    op(2, 1, 16'h0010, 32'h3333_3333, 3'd2, 3'd0, -1, "R6");  // write miss
    op(0, 0, 16'h0010, '0,           3'd1, 3'd0,  1, "R8");  // A was invalidated
    op(0, 0, 16'h0021, '0,           3'd1, 3'd0,  0, "R3");  // A gets E
    op(1, 0, 16'h0021, '0,           3'd1, 3'd0,  1, "R7");  // A E->S
    op(0, 1, 16'h0021, 32'h4444_4444, 3'd3, 3'd0, -1, "R7");  // not silent any more
    op(0, 0, 16'h0025, '0,           3'd4, 3'd1,  0, "R9");  // M victim written back
    op(1, 0, 16'h0021, '0,           3'd1, 3'd0,  0, "R9");  // sees written-back word
    op(1, 1, 16'h0021, 32'h5555_5555, 3'd0, 3'd0, -1, "R4");  // silent again
    op(2, 0, 16'h0014, '0,           3'd1, 3'd0,  0, "R9");  // S victim silent
    op(2, 1, 16'h0021, 32'h6666_6666, 3'd2, 3'd0, -1, "R8");  // B M flushes, invalid
    op(2, 0, 16'h0021, '0,           3'd0, 3'd0, -1, "R2");  // read hit
    op(1, 0, 16'h0021, '0,           3'd1, 3'd0,  1, "R10"); // latest value
    op(0, 0, 16'h0010, '0,           3'd0, 3'd0, -1, "R10"); // still shared copy
    repeat (3) @(negedge clk);
    check(sbq.size() == 0, "R10", "pending completions", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule